// File: doc/BRIEF.md
# Programmable Trigger Detector for External Interrupt Pins

This block watches one to eight external interrupt pins that are asynchronous to the core clock. It produces one detect output per pin for the pending-status stage that follows. Each pin is first brought into the clock domain by a chain of synchronising flops. The synchronised value is then compared with its value one cycle earlier. A per-pin trigger mode selects whether the detect output is a one-cycle pulse on a falling edge, a rising edge or either edge, or a level that follows the synchronised pin (active low or active high).

The trigger modes live in one 32-bit configuration word. Each pin owns a field of 2 or 4 bits, and the width is chosen when the block is elaborated. Fields are packed from the top of the word downward, so pin 0 holds the most significant field. Software can load the whole word in one write. It can also update one pin's field through a separate field-write port, which refuses any mode value that the field width cannot hold.

Both write ports are plain strobed control inputs and always complete in one cycle. The detect outputs are plain per-pin signals. There is no handshake and no back-pressure: the pending stage downstream latches the pulses itself.

Top module: `pin_trigger_detect`

## Requirements
- R1: After reset every field is 0 (falling-edge mode), and with the pins held low every detect output is 0.
- R2: Mode code 0 (falling edge): a high-to-low change on a pin that comes before clock edge k raises that pin's detect for exactly the one cycle after edge k+1.
- R3: Mode code 1 (rising edge): a low-to-high change that comes before edge k raises detect for exactly the one cycle after edge k+1.
- R4: Mode code 2 (low level): detect equals the inverse of the pin as sampled two clock edges earlier, for as long as the mode is held.
- R5: Mode code 3 (high level): detect equals the pin as sampled two clock edges earlier.
- R6: Mode code 4 (both edges): any change of the pin produces a one-cycle detect pulse, timed as in R2 and R3.
- R7: Pin n's field occupies word bits [32-(n+1)*FIELD_W +: FIELD_W]. With 4-bit fields, pin 0 is bits [31:28] and pin 7 is bits [3:0]. A whole-word write takes effect from the clock edge that captures it.
- R8: A field write whose mode value is 2**FIELD_W or more, or whose pin index is NUM_PINS or more, is ignored and leaves the configuration unchanged. When both ports write in the same cycle, a field write that is accepted overrides its field of the word write.
- R9: Field codes 5 to 15 (possible only with 4-bit fields) produce no detection at all.
- R10: Pins are independent: a change on one pin, or on one pin's mode, never moves another pin's detect output, for any NUM_PINS from 1 to 8.
- R11: With 2-bit fields, pin 0 is bits [31:30], pin 1 is bits [29:28] and pin 2 is bits [27:26], and the both-edges code cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Raw external interrupt pins, asynchronous |
| word_we_i | input | 1 | Strobe: load the whole configuration word |
| word_wdata_i | input | 32 | Configuration word, pin 0 in the top field |
| fld_we_i | input | 1 | Strobe: write a single pin's field |
| fld_pin_i | input | 3 | Pin index for the field write |
| fld_mode_i | input | 4 | Mode code for the field write |
| detect_o | output | NUM_PINS | Per-pin detect pulse or level |

## Verification
The trigger decode is driven with a single pin rising, all pins falling together, a pin toggling in both-edges mode, and pins held steady in level modes. These patterns separate edge pulses from level tracking, and they show whether a pulse lasts exactly one cycle. Words that set a single edge-mode field among inert codes confirm that the top field is pin 0 and the bottom field is pin 7. A word made only of codes 5 to 15, run with full toggles, must produce no output. A second instance with three pins and 2-bit fields receives a both-edges field write that must be refused. The bench checks this by showing that a falling edge still gives no pulse: a truncated code would have turned the pin into a falling-edge detector.

// File: rtl/pin_sense_pkg.sv
package pin_sense_pkg;
  localparam int SENSE_W = 32;
  localparam int MODE_W  = 4;
  localparam int PIN_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    TRIG_FALL = 4'd0,
    TRIG_RISE = 4'd1,
    TRIG_LOW  = 4'd2,
    TRIG_HIGH = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_mode_e;
endpackage

// File: rtl/pin_sync_edge.sv
module pin_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic cur_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign cur_o  = chain_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/sense_cfg_reg.sv
module sense_cfg_reg
  import pin_sense_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int FIELD_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_we_i,
  input  logic [SENSE_W-1:0] word_wdata_i,
  input  logic               fld_we_i,
  input  logic [PIN_W-1:0]   fld_pin_i,
  input  logic [MODE_W-1:0]  fld_mode_i,
  output logic [SENSE_W-1:0] sense_o
);
  logic [SENSE_W-1:0] sense_q;
  logic [SENSE_W-1:0] sense_d;
  logic               mode_fits;
  logic               pin_ok;

  // A mode that needs bits above the field width has no encoding.
  assign mode_fits = (fld_mode_i >> FIELD_W) == '0;
  assign pin_ok    = int'(fld_pin_i) < NUM_PINS;

  always_comb begin
    sense_d = word_we_i ? word_wdata_i : sense_q;
    if (fld_we_i && mode_fits && pin_ok) begin
      for (int n = 0; n < NUM_PINS; n++) begin
        if (int'(fld_pin_i) == n)
          sense_d[SENSE_W-(n+1)*FIELD_W +: FIELD_W] = fld_mode_i[FIELD_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sense_q <= '0;
    else        sense_q <= sense_d;
  end

  assign sense_o = sense_q;
endmodule

// File: rtl/trig_decode.sv
module trig_decode
  import pin_sense_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic [FIELD_W-1:0] mode_i,
  input  logic               cur_i,
  input  logic               prev_i,
  output logic               det_o
);
  logic [MODE_W-1:0] code;
  assign code = MODE_W'(mode_i);

  always_comb begin
    case (code)
      TRIG_FALL: det_o = !cur_i && prev_i;
      TRIG_RISE: det_o = cur_i && !prev_i;
      TRIG_LOW:  det_o = !cur_i;
      TRIG_HIGH: det_o = cur_i;
      TRIG_BOTH: det_o = cur_i ^ prev_i;
      default:   det_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/pin_trigger_detect.sv
module pin_trigger_detect
  import pin_sense_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int FIELD_W     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                word_we_i,
  input  logic [31:0]         word_wdata_i,
  input  logic                fld_we_i,
  input  logic [2:0]          fld_pin_i,
  input  logic [3:0]          fld_mode_i,
  output logic [NUM_PINS-1:0] detect_o
);
  logic [SENSE_W-1:0]  sense_q;
  logic [NUM_PINS-1:0] sync_cur;
  logic [NUM_PINS-1:0] sync_prev;

  sense_cfg_reg #(
    .NUM_PINS(NUM_PINS),
    .FIELD_W (FIELD_W)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_we_i   (word_we_i),
    .word_wdata_i(word_wdata_i),
    .fld_we_i    (fld_we_i),
    .fld_pin_i   (fld_pin_i),
    .fld_mode_i  (fld_mode_i),
    .sense_o     (sense_q)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    localparam int LSB = SENSE_W - (n + 1) * FIELD_W;

    pin_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pins_i[n]),
      .cur_o (sync_cur[n]),
      .prev_o(sync_prev[n])
    );

    trig_decode #(.FIELD_W(FIELD_W)) u_dec (
      .mode_i(sense_q[LSB +: FIELD_W]),
      .cur_i (sync_cur[n]),
      .prev_i(sync_prev[n]),
      .det_o (detect_o[n])
    );
  end
endmodule

// File: rtl/pin_trigger_detect_chk.sv
module pin_trigger_detect_chk #(
  parameter int NUM_PINS = 8,
  parameter int FIELD_W  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pins_i,
  input logic                word_we_i,
  input logic                fld_we_i,
  input logic [2:0]          fld_pin_i,
  input logic [3:0]          fld_mode_i,
  input logic [NUM_PINS-1:0] detect_o,
  input logic [31:0]         sense_q
);
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  logic bad_fld;
  assign bad_fld = fld_we_i && !word_we_i &&
                   ((int'(fld_pin_i) >= NUM_PINS) || ((fld_mode_i >> FIELD_W) != 4'd0));

  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_fld |=> $stable(sense_q)) else $error("rejected write changed config"); // R8

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_chk
    logic [3:0] code;
    assign code = 4'(sense_q[32-(n+1)*FIELD_W +: FIELD_W]);

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 4'd0 && detect_o[n]) |=> (!detect_o[n] || $changed(sense_q)))
      else $error("fall pulse too long"); // R2
    AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (code == 4'd1 && detect_o[n]) |=> (!detect_o[n] || $changed(sense_q)))
      else $error("rise pulse too long"); // R3
    AST_LOW_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 2'd2 && code == 4'd2) |-> (detect_o[n] == !$past(pins_i[n], 2)))
      else $error("low level mismatch"); // R4
    AST_HIGH_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q >= 2'd2 && code == 4'd3) |-> (detect_o[n] == $past(pins_i[n], 2)))
      else $error("high level mismatch"); // R5
    AST_BOTH_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd3 && code == 4'd4) |->
        (detect_o[n] == ($past(pins_i[n], 2) != $past(pins_i[n], 3))))
      else $error("both-edge mismatch"); // R6
    AST_INERT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (code > 4'd4) |-> !detect_o[n]) else $error("inert code detected"); // R9
  end
endmodule

bind pin_trigger_detect pin_trigger_detect_chk #(
  .NUM_PINS(NUM_PINS),
  .FIELD_W (FIELD_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pins_i    (pins_i),
  .word_we_i (word_we_i),
  .fld_we_i  (fld_we_i),
  .fld_pin_i (fld_pin_i),
  .fld_mode_i(fld_mode_i),
  .detect_o  (detect_o),
  .sense_q   (sense_q)
);

// File: tb/pin_trigger_detect_test.sv
module pin_trigger_detect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic        word_we = 1'b0;
  logic [31:0] word_wd = '0;
  logic        fld_we = 1'b0;
  logic [2:0]  fld_pin = '0;
  logic [3:0]  fld_mode = '0;
  logic [7:0]  det;

  logic [2:0]  pins2 = '0;
  logic        word_we2 = 1'b0;
  logic [31:0] word_wd2 = '0;
  logic        fld_we2 = 1'b0;
  logic [2:0]  fld_pin2 = '0;
  logic [3:0]  fld_mode2 = '0;
  logic [2:0]  det2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10ns clk = ~clk;

  pin_trigger_detect #(.NUM_PINS(8), .FIELD_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .pins_i(pins),
    .word_we_i(word_we), .word_wdata_i(word_wd),
    .fld_we_i(fld_we), .fld_pin_i(fld_pin), .fld_mode_i(fld_mode),
    .detect_o(det)
  );

  pin_trigger_detect #(.NUM_PINS(3), .FIELD_W(2)) uut2 (
    .clk(clk), .rst_n(rst_n), .pins_i(pins2),
    .word_we_i(word_we2), .word_wdata_i(word_wd2),
    .fld_we_i(fld_we2), .fld_pin_i(fld_pin2), .fld_mode_i(fld_mode2),
    .detect_o(det2)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_word(logic [31:0] w);
    word_wd = w; word_we = 1'b1; step(); word_we = 1'b0;
  endtask

  task automatic wr_word2(logic [31:0] w);
    word_wd2 = w; word_we2 = 1'b1; step(); word_we2 = 1'b0;
  endtask

  task automatic wr_fld(logic [2:0] p, logic [3:0] m);
    fld_pin = p; fld_mode = m; fld_we = 1'b1; step(); fld_we = 1'b0;
  endtask

  task automatic wr_fld2(logic [2:0] p, logic [3:0] m);
    fld_pin2 = p; fld_mode2 = m; fld_we2 = 1'b1; step(); fld_we2 = 1'b0;
  endtask

  // R1: reset state, default falling-edge mode
  task automatic t_reset();
    check("R1 idle after reset", det, 8'h00);
    pins = 8'hFF; step(); check("R1 rise ignored", det, 8'h00);
    step(); check("R1 rise ignored", det, 8'h00);
    pins = 8'h00; step(); check("R2 before sync", det, 8'h00);
    step(); check("R2 all pins fall pulse", det, 8'hFF);
    step(); check("R2 pulse one cycle", det, 8'h00);
  endtask

  // R3, R10: one pin rising
  task automatic t_rise();
    wr_word(32'h1111_1111);
    pins = 8'h08; step(); check("R3 before sync", det, 8'h00);
    step(); check("R3 R10 rise on pin3 only", det, 8'h08);
    step(); check("R3 pulse one cycle", det, 8'h00);
    pins = 8'h00; step(); step(); check("R3 fall ignored", det, 8'h00);
    step();
  endtask

  // R7, R2: field placement, pin 7 in lowest nibble, pin 0 in top nibble
  task automatic t_layout();
    wr_word(32'h5555_5550);
    pins = 8'hFF; step(); step(); step(); check("R7 rise ignored", det, 8'h00);
    pins = 8'h00; step(); step(); check("R7 R2 pin7 is bottom field", det, 8'h80);
    step(); check("R2 pulse one cycle", det, 8'h00);
    wr_word(32'h1555_5555);
    pins = 8'hFF; step(); step(); check("R7 pin0 is top field", det, 8'h01);
    step(); check("R3 pulse one cycle", det, 8'h00);
    pins = 8'h00; step(); step(); step();
  endtask

  // R4, R5, R10: level modes through field writes
  task automatic t_level();
    wr_word(32'h5555_5555);
    wr_fld(3'd5, 4'd2);
    wr_fld(3'd6, 4'd3);
    check("R4 low level with pin low", det, 8'h20);
    pins = 8'h60; step(); check("R4 two-edge latency", det, 8'h20);
    step(); check("R5 high level follows pin", det, 8'h40);
    step(); check("R5 level holds", det, 8'h40);
    pins = 8'h00; step(); check("R5 latency on release", det, 8'h40);
    step(); check("R4 low level returns", det, 8'h20);
  endtask

  // R6: both edges
  task automatic t_both();
    wr_word(32'h5545_5555);
    pins = 8'h04; step(); check("R6 before sync", det, 8'h00);
    step(); check("R6 rise pulse", det, 8'h04);
    step(); check("R6 one cycle", det, 8'h00);
    pins = 8'h00; step(); step(); check("R6 fall pulse", det, 8'h04);
    step(); check("R6 one cycle", det, 8'h00);
  endtask

  // R9: inert codes
  task automatic t_inert();
    wr_word(32'h5678_9ABF);
    pins = 8'hFF;
    for (int k = 0; k < 3; k++) begin step(); check("R9 inert on rise", det, 8'h00); end
    pins = 8'h00;
    for (int k = 0; k < 3; k++) begin step(); check("R9 inert on fall", det, 8'h00); end
  endtask

  // R11, R10: 2-bit fields on a 3-pin instance
  task automatic t_narrow();
    wr_word2(32'h7800_0000);
    check("R11 pin2 low level", {5'd0, det2}, 8'h04);
    pins2 = 3'b111; step(); check("R11 latency", {5'd0, det2}, 8'h04);
    step(); check("R11 pin0 rise, pin1 high", {5'd0, det2}, 8'h03);
    step(); check("R11 pin0 pulse ends", {5'd0, det2}, 8'h02);
  endtask

  // R8: refused field writes
  task automatic t_reject();
    wr_fld2(3'd0, 4'd4);
    wr_fld2(3'd3, 4'd0);
    pins2 = 3'b000; step(); check("R8 latency", {5'd0, det2}, 8'h02);
    step(); check("R8 pin0 still rise mode on fall", {5'd0, det2}, 8'h04);
    pins2 = 3'b111; step(); step(); check("R8 pin0 rise kept", {5'd0, det2}, 8'h03);
    wr_fld2(3'd0, 4'd0);
    pins2 = 3'b000; step(); step(); check("R8 valid field write accepted", {5'd0, det2}, 8'h05);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_rise();
    t_layout();
    t_level();
    t_both();
    t_inert();
    t_narrow();
    t_reject();
    done = 1'b1;
    summary();
  end

  initial begin
    #4ms;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end
endmodule